// File: doc/BRIEF.md
# Summed Trigger Primitive Framer

The block accepts one set of 64 digitized channel samples per beam crossing and turns it into a compact trigger frame. Each sample is first multiplied by its own 8-bit gain value, where 64 means unity, and the product is truncated. The channels form an 8x8 grid. Each non-overlapping 2x2 tile of that grid is added into one tower sum, which gives 16 sums. Each sum is shifted down to a linear 8-bit scale and saturates at 255. The frame is ten 16-bit words on consecutive clock cycles: a fixed marker word, a header word carrying a wrapping crossing count, and eight data words with two sums in each.

A crossing strobe starts a frame. The framer runs much faster than the crossing rate, so a frame ends well before the next crossing arrives. A strobe that arrives while a frame is still being sent is dropped. The gain table is loaded through a single-cycle address/data write port. The sums are captured when the strobe is accepted, so a table write during a frame does not change that frame.

Top module: `trig_prim_framer`

## Requirements
- R1: After reset, `word_valid` and `word_marker` are low until the first strobe. The first frame's header count is 0, and every gain entry is 64 (unity).
- R2: When `xing_valid` is high on an edge where no frame is in progress, the frame is accepted. Ten words follow with `word_valid` high from the next cycle on, with no gaps: the marker, then the header, then data words 0 to 7. `word_valid` is low between frames.
- R3: The marker word is 16'hBC50. `word_marker` is high only while that first word of a frame is on `word_out`.
- R4: The header word is {8'h5A, count}. The count increases by one for each accepted frame and wraps from 255 to 0.
- R5: Channel c sits at grid row c/8 and column c%8, with samples packed as `samples[c*14 +: 14]`. Group g (0 to 15) covers rows 2*(g/4) and 2*(g/4)+1 and columns 2*(g%4) and 2*(g%4)+1. Data word k carries group 2k in bits 15:8 and group 2k+1 in bits 7:0.
- R6: Each channel's corrected value is floor(sample * gain / 64).
- R7: A group's output is floor(sum of its four corrected values / 256). When that exceeds 255 it is sent as 255; it never wraps.
- R8: A strobe on an edge where a frame is in progress is ignored. No extra words appear and the frame in progress is unchanged.
- R9: When `gain_we` is high on an edge, `gain_data` is written to entry `gain_addr` and applies to later accepted strobes. A write during a frame does not alter the words of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_valid | input | 1 | Crossing strobe; the samples are valid on this edge |
| samples | input | 896 | 64 channels x 14-bit samples, channel c at bits c*14 +: 14 |
| gain_we | input | 1 | Gain table write enable |
| gain_addr | input | 6 | Gain table entry (channel) to write |
| gain_data | input | 8 | Gain multiplier in units of 1/64 |
| word_out | output | 16 | Frame word |
| word_valid | output | 1 | word_out holds a frame word |
| word_marker | output | 1 | word_out holds the frame marker |

## Verification
An all-zero crossing and a uniform crossing show the frame layout and the unity-gain path without depending on position. A per-channel ramp of sample values gives each tower a different sum, so a wrong grid mapping or byte order shows up at once. Full-scale samples at unity gain land exactly on 255, while raised gains push past it, which separates correct clamping from wrapping. Varied gains test the truncating correction. A second strobe and a table write, both issued in the middle of a frame, must leave that frame untouched, and 260 frames in a row carry the header count across its wrap.

// File: rtl/trig_prim_framer.sv
module trig_prim_framer #(
  parameter int GRID     = 8,
  parameter int SW       = 14,
  parameter int GW       = 8,
  parameter int GFRAC    = 6,
  parameter int SCALE_SH = 8,
  parameter logic [15:0] MARKER  = 16'hBC50,
  parameter logic [7:0]  HDR_TAG = 8'h5A,
  localparam int NCH  = GRID * GRID,
  localparam int NGRP = NCH / 4,
  localparam int NDW  = NGRP / 2,
  localparam int AW   = $clog2(NCH),
  localparam int CW   = SW + GW - GFRAC,
  localparam int SUMW = CW + 2,
  localparam int NW   = NDW + 2,
  localparam int IW   = $clog2(NW),
  localparam int DIW  = $clog2(NDW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xing_valid,
  input  logic [NCH*SW-1:0] samples,
  input  logic              gain_we,
  input  logic [AW-1:0]     gain_addr,
  input  logic [GW-1:0]     gain_data,
  output logic [15:0]       word_out,
  output logic              word_valid,
  output logic              word_marker
);

  logic [GW-1:0] gain_q [NCH];
  logic [7:0]    sum_d  [NGRP];
  logic [7:0]    sum_q  [NGRP];
  logic [15:0]   data_w [NDW];
  logic [7:0]    cnt_q, hdr_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;

  wire accept = xing_valid && !busy_q;
  wire last   = idx_q == IW'(NW - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) gain_q[i] <= GW'(1 << GFRAC);
    end else if (gain_we) begin
      gain_q[gain_addr] <= gain_data;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int R0 = 2 * (g / (GRID / 2));
    localparam int C0 = 2 * (g % (GRID / 2));
    localparam int CH0 = R0 * GRID + C0;
    logic [SW+GW-1:0] prod [4];
    logic [CW-1:0]    corr [4];
    logic [SUMW-1:0]  tot, scaled;
    for (genvar t = 0; t < 4; t++) begin : g_tap
      localparam int CH = CH0 + (t / 2) * GRID + (t % 2);
      assign prod[t] = samples[CH*SW +: SW] * gain_q[CH];
      assign corr[t] = prod[t][SW+GW-1:GFRAC];
    end
    assign tot    = {2'b0, corr[0]} + {2'b0, corr[1]} + {2'b0, corr[2]} + {2'b0, corr[3]};
    assign scaled = tot >> SCALE_SH;
    assign sum_d[g] = (|scaled[SUMW-1:8]) ? 8'hFF : scaled[7:0];
  end

  for (genvar k = 0; k < NDW; k++) begin : g_dw
    assign data_w[k] = {sum_q[2*k], sum_q[2*k+1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      for (int i = 0; i < NGRP; i++) sum_q[i] <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      hdr_q  <= cnt_q;
      cnt_q  <= cnt_q + 8'd1;
      for (int i = 0; i < NGRP; i++) sum_q[i] <= sum_d[i];
    end else if (busy_q) begin
      busy_q <= !last;
      idx_q  <= last ? '0 : idx_q + IW'(1);
    end
  end

  wire [IW-1:0] di = idx_q - IW'(2);

  assign word_valid  = busy_q;
  assign word_marker = busy_q && idx_q == '0;
  assign word_out    = !busy_q       ? 16'h0000 :
                       idx_q == '0   ? MARKER :
                       idx_q == IW'(1) ? {HDR_TAG, hdr_q} :
                       data_w[di[DIW-1:0]];

  // R3
  marker_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_marker |-> (word_valid && word_out == MARKER));
  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xing_valid && !word_valid) |=> word_marker);
  // R2
  header_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_marker |=> (word_valid && !word_marker && word_out[15:8] == HDR_TAG));
  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_marker) |-> ($stable(hdr_q) && $stable(sum_q[0])));
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_marker |=> (word_out[7:0] + 8'd1 == cnt_q));

endmodule

// File: tb/tb_trig_prim_framer.sv
module tb_trig_prim_framer;
  localparam int NCH = 64;
  localparam int SW  = 14;

  logic clk = 0, rst_n = 0, xing_valid = 0, gain_we = 0;
  logic [NCH*SW-1:0] samples = '0;
  logic [5:0] gain_addr = '0;
  logic [7:0] gain_data = '0;
  logic [15:0] word_out;
  logic word_valid, word_marker;

  trig_prim_framer dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [16:0] expq [$];
  int gm [NCH];
  int fcount = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_frame(input logic [NCH*SW-1:0] s);
    int sums [16];
    for (int g = 0; g < 16; g++) begin
      int r0 = 2 * (g / 4);
      int c0 = 2 * (g % 4);
      int tot = 0;
      for (int t = 0; t < 4; t++) begin
        int ch = (r0 + t / 2) * 8 + c0 + t % 2;
        tot += (int'(s[ch*SW +: SW]) * gm[ch]) / 64;
      end
      tot = tot / 256;
      sums[g] = tot > 255 ? 255 : tot;
    end
    expq.push_back({1'b1, 16'hBC50});
    expq.push_back({1'b0, 8'h5A, 8'(fcount)});
    for (int k = 0; k < 8; k++)
      expq.push_back({1'b0, 8'(sums[2*k]), 8'(sums[2*k+1])});
    fcount = (fcount + 1) % 256;
  endtask

  task automatic send(input logic [NCH*SW-1:0] s);
    push_frame(s);
    @(posedge clk); #1;
    samples = s; xing_valid = 1;
    @(posedge clk); #1;
    xing_valid = 0;
    repeat (10) @(posedge clk);
  endtask

  task automatic wgain(input int a, input int v);
    @(posedge clk); #1;
    gain_we = 1; gain_addr = 6'(a); gain_data = 8'(v);
    @(posedge clk); #1;
    gain_we = 0;
    gm[a] = v;
  endtask

  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (expq.size() == 0) begin
        chk(0, "R8 unexpected word", int'(word_out), 0);
      end else begin
        logic [16:0] e;
        e = expq.pop_front();
        chk(word_out == e[15:0], "R2/R4/R5/R6/R7 word", int'(word_out), int'(e[15:0]));
        chk(word_marker == e[16], "R3 marker flag", int'(word_marker), int'(e[16]));
      end
    end else if (rst_n) begin
      chk(word_marker == 0, "R3 marker without word", int'(word_marker), 0);
    end
  end

  function automatic logic [NCH*SW-1:0] fill(input int mode);
    logic [NCH*SW-1:0] s;
    for (int c = 0; c < NCH; c++) begin
      int v;
      case (mode)
        0: v = 0;
        1: v = 1000;
        2: v = c * 200;
        3: v = 16383;
        default: v = (c * 7919 + 123) % 16384;
      endcase
      s[c*SW +: SW] = 14'(v);
    end
    return s;
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) gm[c] = 64;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 idle after reset
    chk(word_valid == 0, "R1 valid after reset", int'(word_valid), 0);
    chk(word_marker == 0, "R1 marker after reset", int'(word_marker), 0);
    send(fill(0));            // R1 header count 0, R2 layout
    send(fill(1));            // R6 unity gain, R7 scale
    send(fill(2));            // R5 grouping ramp
    send(fill(3));            // R7 exactly 255
    wgain(5, 255);            // R9 write
    wgain(40, 200);
    send(fill(3));            // R7 saturation
    for (int c = 0; c < NCH; c++) wgain(c, (c * 4 + 3) % 256);
    send(fill(4));            // R6 varied gains
    // R8 strobe during frame ignored; R9 write during frame has no effect
    push_frame(fill(2));
    @(posedge clk); #1;
    samples = fill(2); xing_valid = 1;
    @(posedge clk); #1;
    xing_valid = 0;
    repeat (3) @(posedge clk); #1;
    samples = fill(3); xing_valid = 1;
    gain_we = 1; gain_addr = 6'd0; gain_data = 8'd255;
    @(posedge clk); #1;
    xing_valid = 0; gain_we = 0; gm[0] = 255;
    repeat (12) @(posedge clk); #1;
    chk(expq.size() == 0, "R8 pending words", expq.size(), 0);
    send(fill(2));            // R9 new gain used later
    // R4 wrap of crossing count
    for (int i = 0; i < 252; i++) send(fill(i % 5));
    repeat (4) @(posedge clk); #1;
    chk(expq.size() == 0, "R2 words missing", expq.size(), 0);
    chk(word_valid == 0, "R2 idle between frames", int'(word_valid), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule